// File: doc/BRIEF.md
# Per-Core Compare Interrupt Unit

This block sits beside a free-running 64-bit timebase that several cores share. It holds one comparator slot for each core. Each slot has its own 64-bit compare value, a 32-bit step value, three banked control bits, a sticky event flag and an interrupt line. When the global enable is set, the slot's compare enable is set and the timebase has reached the compare value (greater than or equal), the slot records an event. If auto-advance is on, the compare value moves forward by the step value on each event, so one setup gives a periodic interrupt stream.

Software reaches every slot through a plain 32-bit register port. A write names a core and a byte offset. A read names a core and an offset and returns its data one cycle later. The control word that a read returns merges the shared control bits, which arrive on an input from the timebase owner, with that core's banked bits. The core count is a parameter from 1 up to `MAX_CORES` (8). The register port is a control path, not a data stream, so it has no back-pressure: a read is accepted every cycle and answered on the next one.

Offset map, with bit positions given in the requirements: 0x08 control, 0x0C event status, 0x10 compare bits 31:0, 0x14 compare bits 63:32, 0x18 step value. Shared control bit 0 is the global enable.

Top module: `cmp_irq_unit`

## Requirements
- R1: After reset, every slot reads zero for its banked control bits, status, both compare halves and step value, and every irq output is low.
- R2: A slot records an event on a clock edge when shared_ctrl[0], its compare-enable bit (control bit 1) and timebase >= compare all hold before that edge. Equality counts. No event occurs while either enable is clear or while the timebase is below the compare value.
- R3: An event sets the status flag (bit 0 at offset 0x0C), and the flag stays set. Writing 1 to bit 0 of 0x0C clears it. Writing 0 there has no effect.
- R4: With auto-advance (control bit 3) set, each event adds the zero-extended 32-bit step value to the 64-bit compare value. There is at most one step per clock, so a compare value that is still at or below the timebase fires again on the next cycle. With auto-advance clear, the compare value does not change on an event.
- R5: irq[i] is high exactly when slot i's status flag is set and its interrupt-enable bit (control bit 2) is set.
- R6: Offsets 0x10 and 0x14 write and read the low and high 32-bit halves of the compare value. A write to one half leaves the other half unchanged.
- R7: A read of offset 0x08 returns shared_ctrl ORed with the slot's banked bits placed at bits 3:1. A control write stores only wr_data[3:1].
- R8: The control bits are banked: a write to one core's registers leaves every other core's registers unchanged.
- R9: When an event and a write-one-to-clear of the status flag fall in the same cycle, the event wins and the flag stays set.
- R10: When a compare-half write and an auto-advance step fall in the same cycle, the written half takes the written value, the other half keeps its value from before that cycle, and the step is dropped.
- R11: rd_data and rd_valid follow rd_en by one cycle. A read of an unmapped offset, or of a core index at or above NUM_CORES, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timebase | input | 64 | Shared count value |
| shared_ctrl | input | 32 | Shared control bits; bit 0 is the global enable |
| wr_en | input | 1 | Register write strobe |
| wr_core | input | 3 | Core index of the write |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_core | input | 3 | Core index of the read |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data |
| irq | output | NUM_CORES | Interrupt line for each core |

## Verification
Two pairs of functions can land in the same clock: an event together with a software clear of the status flag, and an auto-advance step together with a software write to a compare half. The bench provokes both by holding the timebase above the compare value with the compare enable on, so that the slot fires on every cycle, and then issuing the clear or the compare write. In the first case the status must still read 1 afterwards. In the second case the written half must read back exactly as written, with no step added, and the other half must be unchanged.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned TB_W      = 64;
  localparam int unsigned STEP_W    = 32;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned MAX_CORES = 8;
  localparam int unsigned CORE_W    = $clog2(MAX_CORES);
  localparam int unsigned BANK_N    = 3;

  // control bit positions (banked bits sit at 3:1)
  localparam int unsigned CB_CMP_EN = 1;
  localparam int unsigned CB_IRQ_EN = 2;
  localparam int unsigned CB_AUTO   = 3;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CMPLO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CMPHI = 5'h14;
  localparam logic [REG_AW-1:0] OFS_STEP  = 5'h18;

  typedef struct packed {
    logic [BANK_N-1:0] bank;    // [0]=cmp_en [1]=irq_en [2]=auto
    logic              status;
    logic [TB_W-1:0]   cmp;
    logic [STEP_W-1:0] step;
  } slot_view_t;
endpackage

// File: rtl/cmp_core_slot.sv
module cmp_core_slot
  import cmp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic [TB_W-1:0]   timebase,
  input  logic              wr_sel,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output slot_view_t        view,
  output logic              irq
);
  localparam int unsigned HALF = TB_W / 2;

  logic [BANK_N-1:0] bank_q;
  logic              status_q;
  logic [TB_W-1:0]   cmp_q;
  logic [STEP_W-1:0] step_q;

  logic ctrl_hit, clr_hit, lo_hit, hi_hit, step_hit;
  logic cmp_en, irq_en, auto_en, fire;

  always_comb begin
    ctrl_hit = wr_sel && (wr_addr == OFS_CTRL);
    clr_hit  = wr_sel && (wr_addr == OFS_STAT) && wr_data[0];
    lo_hit   = wr_sel && (wr_addr == OFS_CMPLO);
    hi_hit   = wr_sel && (wr_addr == OFS_CMPHI);
    step_hit = wr_sel && (wr_addr == OFS_STEP);
    cmp_en   = bank_q[CB_CMP_EN-1];
    irq_en   = bank_q[CB_IRQ_EN-1];
    auto_en  = bank_q[CB_AUTO-1];
    fire     = glb_en && cmp_en && (timebase >= cmp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= '0;
      status_q <= 1'b0;
      cmp_q    <= '0;
      step_q   <= '0;
    end else begin
      if (ctrl_hit) bank_q <= wr_data[CB_AUTO:CB_CMP_EN];
      if (step_hit) step_q <= wr_data[STEP_W-1:0];
      // event beats a same-cycle clear
      if (fire)         status_q <= 1'b1;
      else if (clr_hit) status_q <= 1'b0;
      // software write beats a same-cycle advance step
      if (lo_hit)                cmp_q[HALF-1:0]    <= wr_data;
      else if (hi_hit)           cmp_q[TB_W-1:HALF] <= wr_data;
      else if (fire && auto_en)  cmp_q <= cmp_q + {{(TB_W-STEP_W){1'b0}}, step_q};
    end
  end

  assign view = '{bank: bank_q, status: status_q, cmp: cmp_q, step: step_q};
  assign irq  = status_q && irq_en;
endmodule

// File: rtl/cmp_read_mux.sv
module cmp_read_mux
  import cmp_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [CORE_W-1:0] rd_core,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [DATA_W-1:0] shared_ctrl,
  input  slot_view_t        views [NUM_CORES],
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned HALF = TB_W / 2;

  slot_view_t        sel;
  logic              sel_ok;
  logic [DATA_W-1:0] word;

  always_comb begin
    sel    = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (rd_core == CORE_W'(i)) begin
        sel    = views[i];
        sel_ok = 1'b1;
      end
    end
    word = '0;
    if (sel_ok) begin
      unique case (rd_addr)
        OFS_CTRL: begin
          word = shared_ctrl;
          word[CB_AUTO:CB_CMP_EN] = shared_ctrl[CB_AUTO:CB_CMP_EN] | sel.bank;
        end
        OFS_STAT:  word = {{(DATA_W-1){1'b0}}, sel.status};
        OFS_CMPLO: word = sel.cmp[HALF-1:0];
        OFS_CMPHI: word = sel.cmp[TB_W-1:HALF];
        OFS_STEP:  word = sel.step;
        default:   word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? word : '0;
    end
  end
endmodule

// File: rtl/cmp_irq_unit.sv
module cmp_irq_unit
  import cmp_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TB_W-1:0]      timebase,
  input  logic [DATA_W-1:0]    shared_ctrl,
  input  logic                 wr_en,
  input  logic [CORE_W-1:0]    wr_core,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [CORE_W-1:0]    rd_core,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [NUM_CORES-1:0] irq
);
  localparam int unsigned GLB_BIT = 0;

  slot_view_t views [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    logic sel_w;
    assign sel_w = wr_en && (wr_core == CORE_W'(g));
    cmp_core_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en   (shared_ctrl[GLB_BIT]),
      .timebase (timebase),
      .wr_sel   (sel_w),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .view     (views[g]),
      .irq      (irq[g])
    );
  end

  cmp_read_mux #(.NUM_CORES(NUM_CORES)) u_rdmux (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_core     (rd_core),
    .rd_addr     (rd_addr),
    .shared_ctrl (shared_ctrl),
    .views       (views),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );
endmodule

// File: rtl/cmp_slot_checker.sv
module cmp_slot_checker
  import cmp_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fire,
  input logic            clr_hit,
  input logic            lo_hit,
  input logic            hi_hit,
  input logic            auto_en,
  input logic            status_q,
  input logic [TB_W-1:0] cmp_q,
  input logic [STEP_W-1:0] step_q
);
  localparam int unsigned HALF = TB_W / 2;

  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_q);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_hit) |=> status_q);

  assert_step_added_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_en && !lo_hit && !hi_hit) |=>
      (cmp_q == $past(cmp_q) + {{(TB_W-STEP_W){1'b0}}, $past(step_q)}));

  assert_cmp_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fire && auto_en) && !lo_hit && !hi_hit) |=> $stable(cmp_q));

  assert_lo_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |=> (cmp_q[TB_W-1:HALF] == $past(cmp_q[TB_W-1:HALF])));

  assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |=> (cmp_q[HALF-1:0] == $past(cmp_q[HALF-1:0])));

  assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_hit) |=> status_q);
endmodule

bind cmp_core_slot cmp_slot_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fire     (fire),
  .clr_hit  (clr_hit),
  .lo_hit   (lo_hit),
  .hi_hit   (hi_hit),
  .auto_en  (auto_en),
  .status_q (status_q),
  .cmp_q    (cmp_q),
  .step_q   (step_q)
);

// File: tb/cmp_irq_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_irq_unit_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] timebase = '0;
  logic [31:0] shared_ctrl = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_core = '0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_core = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [NC-1:0] irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_irq_unit #(.NUM_CORES(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .timebase(timebase), .shared_ctrl(shared_ctrl),
    .wr_en(wr_en), .wr_core(wr_core), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_core(rd_core), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input int core, input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_core = 3'(core); wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int core, input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_core = 3'(core); rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 rd_valid", 64'(rd_valid), 64'd1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      rd(c, 5'h08, d); chk("R1 ctrl", 64'(d), 64'd0);
      rd(c, 5'h0C, d); chk("R1 status", 64'(d), 64'd0);
      rd(c, 5'h10, d); chk("R1 cmp lo", 64'(d), 64'd0);
      rd(c, 5'h14, d); chk("R1 cmp hi", 64'(d), 64'd0);
      rd(c, 5'h18, d); chk("R1 step", 64'(d), 64'd0);
    end
    chk("R1 irq", 64'(irq), 64'd0);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    wr(2, 5'h10, 32'h1111_2222);
    wr(2, 5'h14, 32'h3333_4444);
    rd(2, 5'h10, d); chk("R6 lo", 64'(d), 64'h1111_2222);
    rd(2, 5'h14, d); chk("R6 hi", 64'(d), 64'h3333_4444);
    wr(2, 5'h10, 32'hAAAA_5555);
    rd(2, 5'h14, d); chk("R6 hi kept", 64'(d), 64'h3333_4444);
    wr(2, 5'h14, 32'h0000_0007);
    rd(2, 5'h10, d); chk("R6 lo kept", 64'(d), 64'hAAAA_5555);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    shared_ctrl = 32'h0000_0300;
    wr(1, 5'h08, 32'hFFFF_FFFF);
    rd(1, 5'h08, d); chk("R7 merged ctrl", 64'(d), 64'h30E);
    rd(0, 5'h08, d); chk("R8 other core ctrl", 64'(d), 64'h300);
    rd(2, 5'h10, d); chk("R8 other core cmp", 64'(d), 64'hAAAA_5555);
    rd(5, 5'h08, d); chk("R11 core out of range", 64'(d), 64'd0);
    rd(1, 5'h1C, d); chk("R11 unmapped offset", 64'(d), 64'd0);
    wr(1, 5'h08, 32'h0);
    rd(1, 5'h08, d); chk("R7 cleared ctrl", 64'(d), 64'h300);
    shared_ctrl = 32'h0;
  endtask

  task automatic t_event();
    logic [31:0] d;
    wr(0, 5'h10, 32'd100);
    wr(0, 5'h08, 32'h6);
    timebase = 64'd99; shared_ctrl = 32'h1;
    @(negedge clk); @(negedge clk);
    rd(0, 5'h0C, d); chk("R2 below compare", 64'(d), 64'd0);
    timebase = 64'd100;
    @(negedge clk);
    chk("R2 equal fires / R5 irq", 64'(irq[0]), 64'd1);
    timebase = 64'd50;
    wr(0, 5'h0C, 32'h0);
    rd(0, 5'h0C, d); chk("R3 write 0 no effect", 64'(d), 64'd1);
    rd(0, 5'h10, d); chk("R4 no auto keeps cmp", 64'(d), 64'd100);
    wr(0, 5'h0C, 32'h1);
    rd(0, 5'h0C, d); chk("R3 w1c clears", 64'(d), 64'd0);
    chk("R5 irq low after clear", 64'(irq[0]), 64'd0);
    timebase = 64'd200; shared_ctrl = 32'h0;
    @(negedge clk); @(negedge clk);
    rd(0, 5'h0C, d); chk("R2 global off", 64'(d), 64'd0);
    shared_ctrl = 32'h1;
    wr(0, 5'h08, 32'h2);
    @(negedge clk);
    rd(0, 5'h0C, d); chk("R2 fires again", 64'(d), 64'd1);
    chk("R5 irq masked", 64'(irq[0]), 64'd0);
    wr(0, 5'h08, 32'h4);
    chk("R5 irq unmasked", 64'(irq[0]), 64'd1);
    wr(0, 5'h08, 32'h0);
    wr(0, 5'h0C, 32'h1);
    chk("R5 irq off", 64'(irq[0]), 64'd0);
    shared_ctrl = 32'h0;
  endtask

  task automatic t_auto();
    logic [31:0] d;
    wr(3, 5'h10, 32'd10);
    wr(3, 5'h18, 32'd5);
    wr(3, 5'h08, 32'hA);
    timebase = 64'd40;
    shared_ctrl = 32'h1;
    @(negedge clk);
    shared_ctrl = 32'h0;
    rd(3, 5'h10, d); chk("R4 one step per clock", 64'(d), 64'd15);
    shared_ctrl = 32'h1;
    repeat (20) @(negedge clk);
    shared_ctrl = 32'h0;
    rd(3, 5'h10, d); chk("R4 catch-up stops past count", 64'(d), 64'd45);
    wr(3, 5'h08, 32'h2);
    timebase = 64'd60; shared_ctrl = 32'h1;
    repeat (4) @(negedge clk);
    shared_ctrl = 32'h0;
    rd(3, 5'h10, d); chk("R4 auto off keeps cmp", 64'(d), 64'd45);
    rd(3, 5'h0C, d); chk("R3 status set", 64'(d), 64'd1);
    wr(3, 5'h0C, 32'h1);
  endtask

  task automatic t_clash();
    logic [31:0] d;
    timebase = 64'd40;
    wr(0, 5'h10, 32'd0);
    wr(0, 5'h08, 32'h2);
    shared_ctrl = 32'h1;
    @(negedge clk);
    wr(0, 5'h0C, 32'h1);
    rd(0, 5'h0C, d); chk("R9 event beats clear", 64'(d), 64'd1);
    wr(0, 5'h08, 32'h0);
    wr(0, 5'h0C, 32'h1);
    rd(0, 5'h0C, d); chk("R3 clear once idle", 64'(d), 64'd0);
    wr(3, 5'h18, 32'd1);
    wr(3, 5'h10, 32'd0);
    wr(3, 5'h08, 32'hA);
    @(negedge clk);
    wr(3, 5'h10, 32'hFFFF_0000);
    @(negedge clk);
    rd(3, 5'h10, d); chk("R10 write beats step", 64'(d), 64'hFFFF_0000);
    rd(3, 5'h14, d); chk("R10 other half kept", 64'(d), 64'd0);
    shared_ctrl = 32'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halves();
    t_ctrl();
    t_event();
    t_auto();
    t_clash();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule